// File: doc/BRIEF.md
# Retired Instruction Result Queue

This block sits between two cores that run the same program. The leading core retires instructions in program order and pushes them here. Each entry holds the instruction word, its PC and, when enabled, the value the leader computed for it. The trailing core fetches from the head of the queue in place of its instruction cache. Because the leader never stalls on a long-latency miss while there is room, the queue becomes a very large, cheap extension of the instruction window.

Several controls shape how the two cores work together. A mode input selects what the trailing core's fetch stage sees. In single-thread mode it sees the queue head. In multi-thread mode it sees its own instruction cache lanes, and the queue is frozen. The full flag is combined with the leader's L2-miss indication into a poison-enable output, which tells the leader whether a missing load may return an invalid value instead of blocking. When the trailing core finds a mispredicted branch, it raises flush, and the queue empties in one cycle.

The depth is a power of two (default 1024). Up to `LANES` entries (default 4) move in and out per cycle. Admission of pushes is decided from the occupancy at the start of the cycle, before that cycle's pops.

Top module: `retire_queue`

## Requirements
- R1: After reset the queue is empty: no fetch lane is valid in single-thread mode, and the full flag is low.
- R2: Entries leave in exactly the order they were accepted, with instruction word and PC unchanged, including across pointer wrap-around. Fetch lane 0 is the oldest entry.
- R3: In single-thread mode without flush, the number of pushes accepted equals the lesser of the requested count and the free slots at the start of the cycle. The accepted entries are lanes 0 upward, and the count is reported on `push_acc` in the same cycle.
- R4: In single-thread mode without flush, the number of entries removed is the lesser of `pop_req`, `LANES` and the occupancy at the start of the cycle. Fetch lane i is valid exactly when i is below that occupancy.
- R5: `q_full` is high exactly when the occupancy equals the depth.
- R6: `poison_en` is high exactly when the mode is single-thread, `l2_miss` is high and the queue is not full.
- R7: `flush` overrides any push or pop in that cycle: `push_acc` is 0 and no fetch lane is valid. From the next cycle the queue is empty.
- R8: In multi-thread mode the fetch outputs copy the instruction-cache lanes and their valid bits, `push_acc` is 0, `poison_en` is 0, and the queue contents and occupancy do not change.
- R9: With the result field enabled, each entry's result value comes out on `fetch_res` with its instruction. Without the result field, `fetch_res` reads 0.
- R10: A push or pop request count above `LANES` is treated as `LANES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| single_mode | input | 1 | 1: trailer fetches from queue; 0: from its own cache |
| flush | input | 1 | Trailing-core mispredict; empties the queue |
| l2_miss | input | 1 | Leader's current load is an L2 miss |
| push_cnt | input | $clog2(LANES+1) | Number of retire lanes offered |
| push_insn | input | LANES*IW | Instruction words, lane 0 oldest |
| push_pc | input | LANES*AW | PCs per lane |
| push_res | input | LANES*RW | Leader results per lane |
| push_acc | output | $clog2(LANES+1) | Lanes accepted this cycle |
| pop_req | input | $clog2(LANES+1) | Entries the trailer consumes |
| ic_valid | input | LANES | Instruction cache lane valid bits |
| ic_insn | input | LANES*IW | Instruction cache words |
| ic_pc | input | LANES*AW | Instruction cache PCs |
| fetch_valid | output | LANES | Fetch lane valid bits |
| fetch_insn | output | LANES*IW | Fetch lane instruction words |
| fetch_pc | output | LANES*AW | Fetch lane PCs |
| fetch_res | output | LANES*RW | Fetch lane predicted results |
| q_full | output | 1 | Queue holds DEPTH entries |
| poison_en | output | 1 | Leader may poison a missing load |

## Verification
The bench sweeps every combination of push and pop count against occupancies from empty to full on an 8-deep queue. This catches a design that admits pushes against the post-pop occupancy, or one that overwrites the oldest entry when it is full. Long runs move the pointers through many wraps, where an off-by-one index would reorder or corrupt entries. A flush is issued together with push and pop requests, which exposes a design that lets one lane slip in during the flush. The bench then switches to multi-thread mode with traffic offered and switches back. A queue that accepted or lost entries while frozen would show a different head on return, and a poison gate that ignored the mode or the full flag shows up on `poison_en`.

// File: rtl/rq_pkg.sv
package rq_pkg;
  // Smaller of two unsigned counts.
  function automatic int unsigned umin(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/rq_ctrl.sv
module rq_ctrl #(
  parameter int DEPTH = 1024,
  parameter int LANES = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             single_mode,
  input  logic                             flush,
  input  logic [$clog2(LANES+1)-1:0]       push_cnt,
  input  logic [$clog2(LANES+1)-1:0]       pop_req,
  output logic [$clog2(DEPTH)-1:0]         wr_ptr,
  output logic [$clog2(DEPTH)-1:0]         rd_ptr,
  output logic [$clog2(DEPTH+1)-1:0]       count,
  output logic [$clog2(LANES+1)-1:0]       push_acc,
  output logic [$clog2(LANES+1)-1:0]       pop_n,
  output logic                             full
);
  import rq_pkg::*;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int NW = $clog2(LANES+1);

  logic [PW-1:0] wr_ptr_n, rd_ptr_n;
  logic [CW-1:0] count_n;
  logic          move_en;

  // Admission is based on start-of-cycle occupancy only.
  always_comb begin
    int unsigned free_slots;
    int unsigned want_push;
    int unsigned want_pop;
    free_slots = DEPTH - int'(count);
    want_push  = umin(int'(push_cnt), LANES);
    want_pop   = umin(umin(int'(pop_req), LANES), int'(count));
    move_en    = single_mode && !flush;
    push_acc   = move_en ? NW'(umin(want_push, free_slots)) : '0;
    pop_n      = move_en ? NW'(want_pop) : '0;
    if (flush) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      count_n  = '0;
    end else begin
      wr_ptr_n = wr_ptr + PW'(push_acc);
      rd_ptr_n = rd_ptr + PW'(pop_n);
      count_n  = count + CW'(push_acc) - CW'(pop_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      count  <= count_n;
    end
  end

  assign full = (count == CW'(DEPTH));

  assert_occupancy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_count_conserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> count == $past(count) + CW'($past(push_acc)) - CW'($past(pop_n)));

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0) && (rd_ptr == wr_ptr));

  assert_pop_within_occupancy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_n) <= count);

  assert_ptr_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> (PW'(wr_ptr - rd_ptr) == PW'(count)));
endmodule

// File: rtl/rq_store.sv
module rq_store #(
  parameter int DEPTH = 1024,
  parameter int LANES = 4,
  parameter int EW    = 64
) (
  input  logic                         clk,
  input  logic [$clog2(DEPTH)-1:0]     wr_ptr,
  input  logic [$clog2(LANES+1)-1:0]   wr_n,
  input  logic [LANES*EW-1:0]          wr_data,
  input  logic [$clog2(DEPTH)-1:0]     rd_ptr,
  output logic [LANES*EW-1:0]          rd_data
);
  localparam int PW = $clog2(DEPTH);

  logic [EW-1:0] mem [DEPTH];

  // Lane k lands at wr_ptr+k when k is below the accepted count.
  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (k < int'(wr_n)) begin
        mem[PW'(wr_ptr + PW'(k))] <= wr_data[k*EW +: EW];
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    assign rd_data[g*EW +: EW] = mem[PW'(rd_ptr + PW'(g))];
  end
endmodule

// File: rtl/rq_fetch_mux.sv
module rq_fetch_mux #(
  parameter int LANES = 4,
  parameter int IW    = 32,
  parameter int AW    = 32,
  parameter int RW    = 32
) (
  input  logic                  single_mode,
  input  logic [LANES-1:0]      q_valid,
  input  logic [LANES*IW-1:0]   q_insn,
  input  logic [LANES*AW-1:0]   q_pc,
  input  logic [LANES*RW-1:0]   q_res,
  input  logic [LANES-1:0]      ic_valid,
  input  logic [LANES*IW-1:0]   ic_insn,
  input  logic [LANES*AW-1:0]   ic_pc,
  output logic [LANES-1:0]      fetch_valid,
  output logic [LANES*IW-1:0]   fetch_insn,
  output logic [LANES*AW-1:0]   fetch_pc,
  output logic [LANES*RW-1:0]   fetch_res
);
  always_comb begin
    if (single_mode) begin
      fetch_valid = q_valid;
      fetch_insn  = q_insn;
      fetch_pc    = q_pc;
      fetch_res   = q_res;
    end else begin
      fetch_valid = ic_valid;
      fetch_insn  = ic_insn;
      fetch_pc    = ic_pc;
      fetch_res   = '0;
    end
  end
endmodule

// File: rtl/retire_queue.sv
module retire_queue #(
  parameter int DEPTH  = 1024,
  parameter int LANES  = 4,
  parameter int IW     = 32,
  parameter int AW     = 32,
  parameter int RW     = 32,
  parameter bit RES_EN = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           single_mode,
  input  logic                           flush,
  input  logic                           l2_miss,
  input  logic [$clog2(LANES+1)-1:0]     push_cnt,
  input  logic [LANES*IW-1:0]            push_insn,
  input  logic [LANES*AW-1:0]            push_pc,
  input  logic [LANES*RW-1:0]            push_res,
  output logic [$clog2(LANES+1)-1:0]     push_acc,
  input  logic [$clog2(LANES+1)-1:0]     pop_req,
  input  logic [LANES-1:0]               ic_valid,
  input  logic [LANES*IW-1:0]            ic_insn,
  input  logic [LANES*AW-1:0]            ic_pc,
  output logic [LANES-1:0]               fetch_valid,
  output logic [LANES*IW-1:0]            fetch_insn,
  output logic [LANES*AW-1:0]            fetch_pc,
  output logic [LANES*RW-1:0]            fetch_res,
  output logic                           q_full,
  output logic                           poison_en
);
  localparam int PW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH+1);
  localparam int NW  = $clog2(LANES+1);
  localparam int REW = RES_EN ? RW : 0;
  localparam int EW  = IW + AW + REW;

  logic [PW-1:0]       wr_ptr, rd_ptr;
  logic [CW-1:0]       count;
  logic [NW-1:0]       pop_n;
  logic [LANES*EW-1:0] wr_data, rd_data;
  logic [LANES-1:0]    q_valid;
  logic [LANES*IW-1:0] q_insn;
  logic [LANES*AW-1:0] q_pc;
  logic [LANES*RW-1:0] q_res;

  rq_ctrl #(.DEPTH(DEPTH), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .single_mode(single_mode), .flush(flush),
    .push_cnt(push_cnt), .pop_req(pop_req), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .count(count), .push_acc(push_acc), .pop_n(pop_n), .full(q_full)
  );

  rq_store #(.DEPTH(DEPTH), .LANES(LANES), .EW(EW)) u_store (
    .clk(clk), .wr_ptr(wr_ptr), .wr_n(push_acc), .wr_data(wr_data),
    .rd_ptr(rd_ptr), .rd_data(rd_data)
  );

  // Entry layout per lane: {result (optional), pc, insn}.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (RES_EN) begin : g_res
      assign wr_data[g*EW +: EW] = {push_res[g*RW +: RW], push_pc[g*AW +: AW], push_insn[g*IW +: IW]};
      assign q_res[g*RW +: RW]   = rd_data[g*EW + IW + AW +: RW];
    end else begin : g_nores
      assign wr_data[g*EW +: EW] = {push_pc[g*AW +: AW], push_insn[g*IW +: IW]};
      assign q_res[g*RW +: RW]   = '0;
    end
    assign q_insn[g*IW +: IW] = rd_data[g*EW +: IW];
    assign q_pc[g*AW +: AW]   = rd_data[g*EW + IW +: AW];
    assign q_valid[g]         = !flush && (count > CW'(g));
  end

  rq_fetch_mux #(.LANES(LANES), .IW(IW), .AW(AW), .RW(RW)) u_mux (
    .single_mode(single_mode), .q_valid(q_valid), .q_insn(q_insn), .q_pc(q_pc),
    .q_res(q_res), .ic_valid(ic_valid), .ic_insn(ic_insn), .ic_pc(ic_pc),
    .fetch_valid(fetch_valid), .fetch_insn(fetch_insn), .fetch_pc(fetch_pc),
    .fetch_res(fetch_res)
  );

  assign poison_en = single_mode && l2_miss && !q_full;

  assert_multi_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !single_mode |-> (push_acc == '0) && !poison_en && (fetch_valid == ic_valid));

  assert_full_blocks_poison_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !poison_en);

  assert_full_blocks_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> push_acc == '0);

  assert_flush_hides_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (push_acc == '0) && (!single_mode || fetch_valid == '0));
endmodule

// File: tb/retire_queue_test.sv
module retire_queue_test;
  localparam int DEPTH = 8;
  localparam int LANES = 4;
  localparam int IW = 16, AW = 16, RW = 16;
  localparam int NW = $clog2(LANES+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic single_mode, flush, l2_miss;
  logic [NW-1:0] push_cnt, pop_req, push_acc;
  logic [LANES*IW-1:0] push_insn, ic_insn, fetch_insn;
  logic [LANES*AW-1:0] push_pc, ic_pc, fetch_pc;
  logic [LANES*RW-1:0] push_res, fetch_res;
  logic [LANES-1:0] ic_valid, fetch_valid;
  logic q_full, poison_en;

  always #10 clk = ~clk;

  retire_queue #(.DEPTH(DEPTH), .LANES(LANES), .IW(IW), .AW(AW), .RW(RW), .RES_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .single_mode(single_mode), .flush(flush), .l2_miss(l2_miss),
    .push_cnt(push_cnt), .push_insn(push_insn), .push_pc(push_pc), .push_res(push_res),
    .push_acc(push_acc), .pop_req(pop_req), .ic_valid(ic_valid), .ic_insn(ic_insn),
    .ic_pc(ic_pc), .fetch_valid(fetch_valid), .fetch_insn(fetch_insn), .fetch_pc(fetch_pc),
    .fetch_res(fetch_res), .q_full(q_full), .poison_en(poison_en)
  );

  int errors = 0;
  int checks = 0;
  int mq [64];
  int head = 0, occ = 0, next_seq = 1;

  function automatic logic [15:0] insn_of(int s); return 16'(16'hA000 + s); endfunction
  function automatic logic [15:0] pc_of(int s);   return 16'(s * 4); endfunction
  function automatic logic [15:0] res_of(int s);  return 16'(s * 7 + 3) ^ 16'h5A5A; endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, check comb outputs, then update the model.
  task automatic step(input bit sm, input bit fl, input int pc, input int pr, input bit l2, input int k);
    int acc, pops, want;
    @(negedge clk);
    single_mode = sm; flush = fl; l2_miss = l2;
    push_cnt = NW'(pc); pop_req = NW'(pr);
    for (int i = 0; i < LANES; i++) begin
      push_insn[i*IW +: IW] = insn_of(next_seq + i);
      push_pc[i*AW +: AW]   = pc_of(next_seq + i);
      push_res[i*RW +: RW]  = res_of(next_seq + i);
      ic_insn[i*IW +: IW]   = 16'(16'h5000 + k * 4 + i);
      ic_pc[i*AW +: AW]     = 16'(16'h0800 + k * 16 + i);
    end
    ic_valid = 4'(k);
    #2;
    want = (pc > LANES) ? LANES : pc;
    acc  = (sm && !fl) ? ((want < DEPTH - occ) ? want : DEPTH - occ) : 0;
    pops = (pr > LANES) ? LANES : pr;
    pops = (sm && !fl) ? ((pops < occ) ? pops : occ) : 0;
    if (pc > LANES) chk(int'(push_acc) == acc, "R10 push clamp", push_acc, acc);
    else if (!sm)   chk(int'(push_acc) == 0, "R8 push ignored", push_acc, 0);
    else if (fl)    chk(int'(push_acc) == 0, "R7 push during flush", push_acc, 0);
    else            chk(int'(push_acc) == acc, "R3 push accepted", push_acc, acc);
    chk(q_full == (occ == DEPTH), "R5 full flag", q_full, occ == DEPTH);
    if (!sm) chk(poison_en == 1'b0, "R8 poison off", poison_en, 0);
    else     chk(poison_en == (l2 && occ != DEPTH), "R6 poison gate", poison_en, l2 && occ != DEPTH);
    if (!sm) begin
      chk(fetch_valid == 4'(k), "R8 icache valid", fetch_valid, k);
      for (int i = 0; i < LANES; i++) begin
        chk(fetch_insn[i*IW +: IW] == 16'(16'h5000 + k * 4 + i), "R8 icache insn",
            fetch_insn[i*IW +: IW], 16'(16'h5000 + k * 4 + i));
        chk(fetch_pc[i*AW +: AW] == 16'(16'h0800 + k * 16 + i), "R8 icache pc",
            fetch_pc[i*AW +: AW], 16'(16'h0800 + k * 16 + i));
      end
    end else begin
      for (int i = 0; i < LANES; i++) begin
        bit ev;
        ev = !fl && (i < occ);
        if (fl) chk(fetch_valid[i] == 1'b0, "R7 lane hidden", fetch_valid[i], 0);
        else    chk(fetch_valid[i] == ev, "R4 lane valid", fetch_valid[i], ev);
        if (ev) begin
          int s;
          s = mq[(head + i) % 64];
          chk(fetch_insn[i*IW +: IW] == insn_of(s), "R2 insn order", fetch_insn[i*IW +: IW], insn_of(s));
          chk(fetch_pc[i*AW +: AW] == pc_of(s), "R2 pc order", fetch_pc[i*AW +: AW], pc_of(s));
          chk(fetch_res[i*RW +: RW] == res_of(s), "R9 result", fetch_res[i*RW +: RW], res_of(s));
        end
      end
    end
    @(posedge clk);
    if (fl) begin
      head = 0; occ = 0;
    end else begin
      for (int i = 0; i < acc; i++) mq[(head + occ + i) % 64] = next_seq + i;
      next_seq += acc;
      occ = occ + acc - pops;
      head = (head + pops) % 64;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    single_mode = 1'b1; flush = 1'b0; l2_miss = 1'b0;
    push_cnt = '0; pop_req = '0; push_insn = '0; push_pc = '0; push_res = '0;
    ic_valid = '0; ic_insn = '0; ic_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(fetch_valid == '0, "R1 reset empty", fetch_valid, 0);
    chk(q_full == 1'b0, "R1 reset not full", q_full, 0);

    // Sweep push/pop counts across many occupancies and wraps.
    for (int rep = 0; rep < 3; rep++)
      for (int pc = 0; pc < 8; pc++)
        for (int pr = 0; pr < 8; pr++)
          step(1'b1, 1'b0, pc, (pr + rep) % 8, (pc + pr) % 2 == 1, 0);

    // Fill to full, poll poison while full.
    repeat (4) step(1'b1, 1'b0, 4, 0, 1'b1, 0);
    step(1'b1, 1'b0, 3, 0, 1'b1, 0);
    step(1'b1, 1'b0, 4, 2, 1'b1, 0);

    // Flush with push and pop requested, then confirm empty.
    step(1'b1, 1'b1, 4, 4, 1'b1, 0);
    step(1'b1, 1'b0, 0, 0, 1'b0, 0);
    chk(occ == 0 && fetch_valid == '0, "R7 empty after flush", fetch_valid, 0);

    // Partly fill, go multi-thread with traffic, come back: head unchanged.
    step(1'b1, 1'b0, 3, 0, 1'b0, 0);
    step(1'b1, 1'b0, 2, 1, 1'b0, 0);
    for (int k = 0; k < 16; k++) step(1'b0, 1'b0, k % 8, (k + 3) % 8, k[0], k);
    step(1'b1, 1'b0, 0, 0, 1'b1, 0);

    // Drain and refill to exercise wrap with mixed rates.
    for (int n = 0; n < 40; n++) step(1'b1, 1'b0, (n * 3) % 5, (n * 5) % 6, n[1], 0);

    finish_run();
  end
endmodule